// File: doc/BRIEF.md
# Laserdisc Frame Seek Sequencer

This block takes a 16-bit binary frame number and a start strobe. It sends the byte sequence that tells a serially remote-controlled laserdisc player to seek to that frame. It turns the number into five decimal digits and assembles the command stream: seek opcodes, a frame-display opcode, the digit bytes with their padding, and closing seek opcodes. The stream goes out one byte at a time on a single remote line, with a long initial pause and a shorter pause before every byte.

Each byte occupies ten equal bit slots: two zero slots, then the eight data bits, most significant first. A companion output marks the slots so that a downstream driver or observer knows when the line carries data. All bit and pause lengths are clock-cycle parameters, so one design runs at a real wall-clock rate or at compressed simulation rates.

The host pulses the start input and then waits for a one-cycle completion pulse. While a seek is in flight, further strobes and changes on the frame input have no effect.

Top module: `ld_seek_sender`

## Requirements
- R1: After reset, rc_line, rc_active, busy and done are all 0.
- R2: An accepted start produces exactly 29 bytes in this order: 0xE8 three times, 0xAC three times, the 20 digit-group bytes, then 0xE8 three times. No further byte follows.
- R3: The digit group carries the five decimal digits of the frame, most significant first, leading zeros included. Each digit is sent as its code byte three times and then one 0x80 pad byte. With the default map, the code for digit d is d placed in bits 7:4 with bits 3:0 zero.
- R4: Each byte is sent as 10 slots of BIT_CYCLES cycles each. rc_active is high for exactly those 10×BIT_CYCLES cycles. The first two slots are 0, followed by bit 7 down to bit 0. rc_line is 0 whenever rc_active is 0.
- R5: rc_active first rises LEAD_CYCLES+GAP_CYCLES cycles after the clock edge that accepted start.
- R6: Between the end of one byte and the start of the next, rc_active stays low for exactly GAP_CYCLES cycles.
- R7: done is a single-cycle pulse. It is high in the first cycle after the last slot of the last byte, and busy falls in that same cycle.
- R8: busy rises in the cycle after an accepted start and stays high until done. rc_active is never high while busy is low.
- R9: A start strobe while busy is ignored, and the frame input is sampled only at the accepted start. The byte stream and its timing are unchanged, and no sequence follows the done pulse.
- R10: The frame values 0 (digits 00000) and 65535 (digits 65535) are sent correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, taken only while idle |
| frame | input | 16 | Target frame number, unsigned binary |
| rc_line | output | 1 | Serial remote-control line |
| rc_active | output | 1 | High during the bit slots of a byte |
| busy | output | 1 | High while a seek sequence is in flight |
| done | output | 1 | One-cycle pulse when the sequence is complete |

## Verification
A bad conversion or a wrong byte index shows up as a wrong byte value at the first affected slot group. For a digit fault, that is the seventh byte. A miscounted timer or bit counter moves the rise or fall of rc_active by at least one cycle, and the very next byte boundary exposes it. A sequencer that mishandles a late strobe either emits bytes after done or changes the digits, which shows up within one byte time of the fault. Every byte is compared against an independently computed queue, together with its slot width and the pause before it.

// File: rtl/ld_seek_pkg.sv
package ld_seek_pkg;
  localparam int FRAME_W    = 16;
  localparam int NDIG       = 5;
  localparam int REP        = 3;
  localparam int BYTE_W     = 8;
  localparam int LEAD_ZEROS = 2;
  localparam int SLOT_BITS  = LEAD_ZEROS + BYTE_W;
  localparam int POS_W      = $clog2(SLOT_BITS);
  localparam int HEAD_BYTES = 2 * REP;
  localparam int DIG_BYTES  = NDIG * (REP + 1);
  localparam int SEQ_BYTES  = HEAD_BYTES + DIG_BYTES + REP;
  localparam int IDX_W      = $clog2(SEQ_BYTES);
  localparam int BCD_W      = 4 * NDIG;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_GAP, ST_SEND} seq_st_t;

  // Byte to send at position idx of the seek stream.
  function automatic logic [BYTE_W-1:0] seek_byte(
    input logic [IDX_W-1:0]          idx,
    input logic [BCD_W-1:0]          bcd,
    input logic [9:0][BYTE_W-1:0]    dmap,
    input logic [BYTE_W-1:0]         seek_cmd,
    input logic [BYTE_W-1:0]         show_cmd,
    input logic [BYTE_W-1:0]         pad);
    int i, k, d, s;
    logic [3:0] nib;
    i = int'(idx);
    seek_byte = seek_cmd;
    if (i < REP) begin
      seek_byte = seek_cmd;
    end else if (i < HEAD_BYTES) begin
      seek_byte = show_cmd;
    end else if (i < HEAD_BYTES + DIG_BYTES) begin
      k = i - HEAD_BYTES;
      d = k / (REP + 1);
      s = k % (REP + 1);
      nib = bcd[4*(NDIG-1-d) +: 4];
      if (s == REP)       seek_byte = pad;
      else if (nib > 4'd9) seek_byte = '0;
      else                 seek_byte = dmap[nib];
    end
  endfunction
endpackage

// File: rtl/ld_bin2bcd.sv
module ld_bin2bcd #(
  parameter int BIN_W = 16,
  parameter int NDIG  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BIN_W-1:0]   bin,
  output logic [4*NDIG-1:0]  bcd,
  output logic               valid
);
  localparam int CNT_W = $clog2(BIN_W + 1);

  logic [BIN_W-1:0]  sr;
  logic [CNT_W-1:0]  left;
  logic [4*NDIG-1:0] bcd_adj;

  // add-3 correction on every digit of five or more
  function automatic logic [4*NDIG-1:0] adj3(input logic [4*NDIG-1:0] v);
    logic [4*NDIG-1:0] r;
    r = v;
    for (int i = 0; i < NDIG; i++)
      if (r[4*i +: 4] >= 4'd5) r[4*i +: 4] = r[4*i +: 4] + 4'd3;
    return r;
  endfunction

  assign bcd_adj = adj3(bcd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      bcd   <= '0;
      left  <= '0;
      valid <= 1'b0;
    end else if (start) begin
      sr    <= bin;
      bcd   <= '0;
      left  <= CNT_W'(BIN_W);
      valid <= 1'b0;
    end else if (left != '0) begin
      bcd  <= {bcd_adj[4*NDIG-2:0], sr[BIN_W-1]};
      sr   <= sr << 1;
      left <= left - 1'b1;
      if (left == CNT_W'(1)) valid <= 1'b1;
    end
  end
endmodule

// File: rtl/ld_tick_timer.sv
module ld_tick_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] value,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= value;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ld_bit_shifter.sv
module ld_bit_shifter
  import ld_seek_pkg::*;
#(
  parameter int BIT_CYCLES = 100_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] data,
  output logic              line,
  output logic              active,
  output logic              fin,
  output logic [POS_W-1:0]  bit_pos
);
  localparam int TICK_W = $clog2(BIT_CYCLES + 1);

  logic [SLOT_BITS-1:0] sh;
  logic [TICK_W-1:0]    tick;
  logic                 slot_end;

  assign slot_end = active && (tick == TICK_W'(BIT_CYCLES - 1));
  assign fin      = slot_end && (bit_pos == POS_W'(SLOT_BITS - 1));
  assign line     = active && sh[SLOT_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      tick    <= '0;
      bit_pos <= '0;
      active  <= 1'b0;
    end else if (load) begin
      sh      <= {{LEAD_ZEROS{1'b0}}, data};
      tick    <= '0;
      bit_pos <= '0;
      active  <= 1'b1;
    end else if (active) begin
      if (slot_end) begin
        tick <= '0;
        if (fin) begin
          active <= 1'b0;
        end else begin
          bit_pos <= bit_pos + 1'b1;
          sh      <= sh << 1;
        end
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ld_seek_sender.sv
module ld_seek_sender
  import ld_seek_pkg::*;
#(
  parameter int BIT_CYCLES  = 100_000,
  parameter int LEAD_CYCLES = 5_000_000,
  parameter int GAP_CYCLES  = 1_000_000,
  parameter logic [BYTE_W-1:0] SEEK_CMD = 8'hE8,
  parameter logic [BYTE_W-1:0] SHOW_CMD = 8'hAC,
  parameter logic [BYTE_W-1:0] PAD_BYTE = 8'h80,
  parameter logic [9:0][BYTE_W-1:0] DIGIT_MAP = {8'h90, 8'h80, 8'h70, 8'h60, 8'h50,
                                                 8'h40, 8'h30, 8'h20, 8'h10, 8'h00}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               rc_line,
  output logic               rc_active,
  output logic               busy,
  output logic               done
);
  localparam int TMR_MAX = (LEAD_CYCLES > GAP_CYCLES) ? LEAD_CYCLES : GAP_CYCLES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  seq_st_t           st;
  logic              accept;
  logic              load_evt;
  logic              fin_evt;
  logic              last_byte;
  logic              tmr_load;
  logic              tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic [IDX_W-1:0]  byte_idx;
  logic [BCD_W-1:0]  bcd;
  logic              conv_valid;
  logic [BYTE_W-1:0] tx_byte;
  logic [POS_W-1:0]  bit_pos;

  assign accept    = start && (st == ST_IDLE);
  assign load_evt  = (st == ST_GAP) && tmr_zero;
  assign last_byte = (byte_idx == IDX_W'(SEQ_BYTES - 1));
  assign busy      = (st != ST_IDLE);
  assign tx_byte   = seek_byte(byte_idx, bcd, DIGIT_MAP, SEEK_CMD, SHOW_CMD, PAD_BYTE);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(LEAD_CYCLES - 1);
    if (accept) begin
      tmr_load = 1'b1;
    end else if ((st == ST_LEAD && tmr_zero) || (fin_evt && !last_byte)) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(GAP_CYCLES - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      byte_idx <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st       <= ST_LEAD;
          byte_idx <= '0;
        end
        ST_LEAD: if (tmr_zero) st <= ST_GAP;
        ST_GAP:  if (tmr_zero) st <= ST_SEND;
        ST_SEND: if (fin_evt) begin
          if (last_byte) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            st       <= ST_GAP;
            byte_idx <= byte_idx + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  ld_bin2bcd #(.BIN_W(FRAME_W), .NDIG(NDIG)) u_conv (
    .clk(clk), .rst_n(rst_n), .start(accept), .bin(frame),
    .bcd(bcd), .valid(conv_valid));

  ld_tick_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .value(tmr_val), .zero(tmr_zero));

  ld_bit_shifter #(.BIT_CYCLES(BIT_CYCLES)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .data(tx_byte),
    .line(rc_line), .active(rc_active), .fin(fin_evt), .bit_pos(bit_pos));
endmodule

// File: rtl/ld_seek_sender_chk.sv
module ld_seek_sender_chk
  import ld_seek_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             rc_line,
  input logic             rc_active,
  input logic             load_evt,
  input logic [IDX_W-1:0] byte_idx,
  input logic [POS_W-1:0] bit_pos,
  input logic             conv_valid,
  input logic [BCD_W-1:0] bcd
);
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_active |-> !rc_line);
  p_lead_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_active && bit_pos < POS_W'(LEAD_ZEROS)) |-> !rc_line);
  p_done_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));
  p_fall_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  p_active_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rc_active |-> busy);
  p_hold_digits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && busy && start) |=> ($stable(bcd) && conv_valid));
  p_digits_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && byte_idx == IDX_W'(HEAD_BYTES)) |-> conv_valid);
  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (byte_idx < IDX_W'(SEQ_BYTES)));
endmodule

bind ld_seek_sender ld_seek_sender_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rc_line(rc_line), .rc_active(rc_active), .load_evt(load_evt),
  .byte_idx(byte_idx), .bit_pos(bit_pos), .conv_valid(conv_valid), .bcd(bcd));

// File: tb/test_ld_seek_sender.sv
module test_ld_seek_sender;
  localparam int BITC  = 4;
  localparam int LEADC = 24;
  localparam int GAPC  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] frame = '0;
  logic        rc_line, rc_active, busy, done;

  always #5 clk = ~clk;

  ld_seek_sender #(.BIT_CYCLES(BITC), .LEAD_CYCLES(LEADC), .GAP_CYCLES(GAPC)) i_ld_seek_sender (
    .clk(clk), .rst_n(rst_n), .start(start), .frame(frame),
    .rc_line(rc_line), .rc_active(rc_active), .busy(busy), .done(done));

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int start_cyc = 0;
  bit first_pending = 0;
  bit seq_done = 0;
  bit idle_err = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: push expected bytes (R2, R3), then strobe start
  task automatic run_seek(input logic [15:0] f, input bit noise);
    int v;
    int dig[5];
    v = int'(f);
    for (int i = 4; i >= 0; i--) begin
      dig[i] = v % 10;
      v = v / 10;
    end
    for (int i = 0; i < 3; i++) exp_q.push_back(8'hE8);
    for (int i = 0; i < 3; i++) exp_q.push_back(8'hAC);
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 3; j++) exp_q.push_back(8'(dig[i] * 16));
      exp_q.push_back(8'h80);
    end
    for (int i = 0; i < 3; i++) exp_q.push_back(8'hE8);
    seq_done = 0;
    @(negedge clk);
    frame = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    start_cyc = cyc;
    first_pending = 1;
    chk(busy === 1'b1, "R8", "busy after accepted start", int'(busy), 1);
    if (noise) begin
      // R9: strobes while busy with another frame value
      repeat (5) @(negedge clk);
      frame = ~f;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (400) @(negedge clk);
      frame = f ^ 16'h1234;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (seq_done);
    @(negedge clk);
    chk(done === 1'b0, "R7", "done lasts one cycle", int'(done), 0);
  endtask

  // monitor: rebuild bytes from the line and compare with the queue
  initial begin : mon
    bit last_act;
    int rise_c;
    int fall_c;
    logic [9:0] bits;
    logic [7:0] e;
    last_act = 0;
    rise_c = 0;
    fall_c = 0;
    bits = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!rc_active && rc_line) idle_err = 1;
        if (rc_active && !last_act) begin
          rise_c = cyc;
          bits = '0;
          if (first_pending) begin
            chk(rise_c - start_cyc == LEADC + GAPC, "R5", "lead delay", rise_c - start_cyc, LEADC + GAPC);
            first_pending = 0;
          end else begin
            chk(rise_c - fall_c == GAPC, "R6", "inter-byte gap", rise_c - fall_c, GAPC);
          end
          chk(!idle_err, "R4", "line low while inactive", int'(idle_err), 0);
          idle_err = 0;
        end
        if (rc_active && ((cyc - rise_c) % BITC) == BITC / 2) bits = {bits[8:0], rc_line};
        if (!rc_active && last_act) begin
          fall_c = cyc;
          chk(fall_c - rise_c == 10 * BITC, "R4", "slot group width", fall_c - rise_c, 10 * BITC);
          chk(bits[9:8] == 2'b00, "R4", "two leading zeros", int'(bits[9:8]), 0);
          if (exp_q.size() == 0) begin
            chk(0, "R9", "byte after sequence end", int'(bits[7:0]), 0);
          end else begin
            e = exp_q.pop_front();
            chk(bits[7:0] == e, "R2 R3", "byte value", int'(bits[7:0]), int'(e));
            if (exp_q.size() == 0) begin
              chk(done === 1'b1 && busy === 1'b0, "R7", "done with busy low", int'({done, busy}), 2);
              seq_done = 1;
            end else begin
              chk(done === 1'b0 && busy === 1'b1, "R8", "busy between bytes", int'({done, busy}), 1);
            end
          end
        end
        last_act = rc_active;
      end else begin
        last_act = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(0, "WD", "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rc_line, rc_active, busy, done} == 4'b0000, "R1", "reset outputs", int'({rc_line, rc_active, busy, done}), 0);
    run_seek(16'd12345, 0);          // R2 R3 main pattern
    run_seek(16'd0, 0);              // R10 all-zero digits
    run_seek(16'd65535, 0);          // R10 largest frame
    run_seek(16'd40907, 0);          // R3 inner zeros, digit 9
    run_seek(16'd7, 1);              // R9 strobes and frame changes while busy
    repeat (200) @(negedge clk);
    chk(!busy && !rc_active && exp_q.size() == 0, "R9", "no extra sequence after done",
        int'({busy, rc_active}), 0);
    wrap_up();
  end
endmodule